// File: doc/BRIEF.md
# Four-Channel Ultrasound Burst Generator

This block times the transmit side of a five-level ultrasound pulser. Each of its four channels has three bridges it can drive: high-voltage bridge 0, high-voltage bridge 1 and a low-current bridge for continuous waves. On the selected bridge the channel drives a positive or a negative level. When it drives nothing it asserts a clamp-to-ground request. Every channel has its own settings: half-period in clock cycles, pulse count, starting polarity, bridge choice and operating mode. A channel set up like its partner but with the starting polarity flipped runs in antiphase with it.

A shared repetition timer raises a one-cycle firing strobe. It does this in the first cycle after `run` goes high, and then once every `rep_period` cycles. An idle channel takes a snapshot of its settings on the strobe and plays a burst. A pulsed burst sends N full pulses on one high-voltage bridge. A two-phase burst sends three half-pulses on bridge 0 and then N full pulses on bridge 1. A continuous channel toggles on the low-current bridge until `run` falls. Dropping `run` stops the timer and returns every channel to the clamp level.

Top module: `sonic_burst_gen`

## Requirements
- R1: `fire` is high only while `run` is high. After `run` rises, `fire` pulses in the first cycle and then again every `rep_period` cycles (`rep_period` >= 1) for as long as `run` stays high.
- R2: A channel starts a burst only at a clock edge where `fire` is high and the channel is idle. It captures its settings at that edge, and the first level appears in the next cycle. A setting changed during a burst takes effect only from the next burst.
- R3: Each level lasts exactly H cycles, where H is the channel's `cfg_half` field. A value of 0 is treated as 1.
- R4: Mode 0 (pulsed) gives 2N half-periods on bridge `cfg_bridge` (0 or 1), where N is `cfg_pulses`. With N = 0 the channel gives no burst.
- R5: The first half-period is positive when `cfg_neg` is 0 and negative when it is 1. Polarity then alternates every half-period.
- R6: Mode 1 (continuous) toggles on bridge 2 without end until `run` falls.
- R7: Mode 2 (two-phase) gives three half-periods on bridge 0, then 2N half-periods on bridge 1. Polarity keeps alternating across the switch.
- R8: At every clock, each channel drives at most one of its six drive bits. While `clamp` is high, all six bits are low. Out of reset, every `clamp` is high and every drive bit is low.
- R9: In the cycle after `run` is seen low, every drive bit is low and every `clamp` is high.
- R10: A channel in mode 3 (off) never drives.
- R11: A strobe that arrives while a channel is still in a burst is ignored by that channel. Its waveform goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables the repetition timer and keeps bursts alive |
| rep_period | input | REP_W | Firing interval in cycles |
| cfg_half | input | NCH*HP_W | Half-period per channel, field c at [c*HP_W +: HP_W] |
| cfg_pulses | input | NCH*CNT_W | Pulse count per channel |
| cfg_mode | input | NCH*2 | Mode per channel: 0 pulsed, 1 continuous, 2 two-phase, 3 off |
| cfg_neg | input | NCH | Start with a negative half-period |
| cfg_bridge | input | NCH | High-voltage bridge used in pulsed mode |
| fire | output | 1 | Repetition strobe |
| drv_pos | output | NCH*3 | Positive drive, bit c*3+b for channel c and bridge b (2 = low-current) |
| drv_neg | output | NCH*3 | Negative drive, same bit layout |
| clamp | output | NCH | Channel holds ground |

## Verification
The fire-spacing property assumes `rep_period` is at least 1 and does not change while `run` is high. The bench only writes `rep_period` while `run` is low. The checks for one burst per strobe assume a burst of half-period times half-count fits inside `rep_period`. Every table entry and directed case respects this, except the continuous cases, where strobes are meant to be ignored. Settings are changed at falling edges only, and in the mid-burst cases they change deliberately, to show that the captured snapshot is what counts.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE = 2'd0,
    MODE_CW    = 2'd1,
    MODE_SPLIT = 2'd2,
    MODE_OFF   = 2'd3
  } burst_mode_e;

  localparam int NBR = 3;   // bridges per channel: two high-voltage, one low-current
  localparam int BR_CW = 2;

  // Half-period as used by the timing counter (zero is promoted to one).
  function automatic int unsigned eff_half(input int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  // Number of half-periods a finite burst contains (0 means no burst).
  function automatic int unsigned burst_halves(input burst_mode_e m,
                                               input int unsigned n,
                                               input int unsigned pre);
    case (m)
      MODE_PULSE: return 2 * n;
      MODE_SPLIT: return pre + 2 * n;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/sbg_rep_timer.sv
module sbg_rep_timer #(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REP_W-1:0] period,
  output logic             fire
);

  logic [REP_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= period - REP_W'(1));
  assign fire = run & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + REP_W'(1);
  end

endmodule

// File: rtl/sbg_channel.sv
module sbg_channel
  import sbg_pkg::*;
#(
  parameter int HP_W       = 8,
  parameter int CNT_W      = 5,
  parameter int PRE_HALVES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fire,
  input  logic [HP_W-1:0]  half_in,
  input  logic [CNT_W-1:0] pulses_in,
  input  logic [1:0]       mode_in,
  input  logic             neg_in,
  input  logic             bridge_in,
  output logic [NBR-1:0]   pos_o,
  output logic [NBR-1:0]   neg_o,
  output logic             active_o
);

  localparam int IDX_W = $clog2(PRE_HALVES + 2 * (2 ** CNT_W)) + 1;

  burst_mode_e       mode_e;
  logic [IDX_W-1:0]  total_in;
  logic [HP_W-1:0]   hp_in;
  logic              startable;
  logic              start;
  logic              half_end;
  logic              last_half;

  logic              act;
  logic              pol;      // 1 = positive level
  logic [1:0]        br;
  logic [HP_W-1:0]   tcnt;
  logic [IDX_W-1:0]  idx;
  logic [HP_W-1:0]   hp_l;
  logic [IDX_W-1:0]  total_l;
  logic              cw_l;
  logic              sp_l;

  assign mode_e    = burst_mode_e'(mode_in);
  assign total_in  = IDX_W'(burst_halves(mode_e, 32'(pulses_in), PRE_HALVES));
  assign hp_in     = HP_W'(eff_half(32'(half_in)));
  assign startable = (mode_e == MODE_CW) || (total_in != '0);
  assign start     = fire & ~act & startable;
  assign half_end  = act & (tcnt == '0);
  assign last_half = half_end & ~cw_l & (idx == total_l - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      pol     <= 1'b0;
      br      <= 2'd0;
      tcnt    <= '0;
      idx     <= '0;
      hp_l    <= '0;
      total_l <= '0;
      cw_l    <= 1'b0;
      sp_l    <= 1'b0;
    end else if (!run) begin
      act <= 1'b0;
    end else if (start) begin
      act     <= 1'b1;
      pol     <= ~neg_in;
      tcnt    <= hp_in - HP_W'(1);
      idx     <= '0;
      hp_l    <= hp_in;
      total_l <= total_in;
      cw_l    <= (mode_e == MODE_CW);
      sp_l    <= (mode_e == MODE_SPLIT);
      if (mode_e == MODE_CW)         br <= 2'(BR_CW);
      else if (mode_e == MODE_SPLIT) br <= 2'd0;
      else                           br <= {1'b0, bridge_in};
    end else if (half_end) begin
      pol  <= ~pol;
      tcnt <= hp_l - HP_W'(1);
      idx  <= idx + IDX_W'(1);
      if (last_half) act <= 1'b0;
      if (sp_l && (idx == IDX_W'(PRE_HALVES - 1))) br <= 2'd1;
    end else if (act) begin
      tcnt <= tcnt - HP_W'(1);
    end
  end

  for (genvar b = 0; b < NBR; b++) begin : g_drv
    assign pos_o[b] = act &  pol & (br == 2'(b));
    assign neg_o[b] = act & ~pol & (br == 2'(b));
  end

  assign active_o = act;

endmodule

// File: rtl/sonic_burst_gen.sv
module sonic_burst_gen
  import sbg_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int HP_W       = 8,
  parameter int CNT_W      = 5,
  parameter int REP_W      = 16,
  parameter int PRE_HALVES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [REP_W-1:0]     rep_period,
  input  logic [NCH*HP_W-1:0]  cfg_half,
  input  logic [NCH*CNT_W-1:0] cfg_pulses,
  input  logic [NCH*2-1:0]     cfg_mode,
  input  logic [NCH-1:0]       cfg_neg,
  input  logic [NCH-1:0]       cfg_bridge,
  output logic                 fire,
  output logic [NCH*NBR-1:0]   drv_pos,
  output logic [NCH*NBR-1:0]   drv_neg,
  output logic [NCH-1:0]       clamp
);

  logic [NCH-1:0] ch_act;

  sbg_rep_timer #(.REP_W(REP_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .period (rep_period),
    .fire   (fire)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sbg_channel #(
      .HP_W       (HP_W),
      .CNT_W      (CNT_W),
      .PRE_HALVES (PRE_HALVES)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .fire      (fire),
      .half_in   (cfg_half[c*HP_W +: HP_W]),
      .pulses_in (cfg_pulses[c*CNT_W +: CNT_W]),
      .mode_in   (cfg_mode[c*2 +: 2]),
      .neg_in    (cfg_neg[c]),
      .bridge_in (cfg_bridge[c]),
      .pos_o     (drv_pos[c*NBR +: NBR]),
      .neg_o     (drv_neg[c*NBR +: NBR]),
      .active_o  (ch_act[c])
    );
    assign clamp[c] = ~ch_act[c];
  end

endmodule

// File: rtl/sonic_burst_gen_chk.sv
module sonic_burst_gen_chk #(
  parameter int NCH   = 4,
  parameter int REP_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [REP_W-1:0]   rep_period,
  input logic               fire,
  input logic [NCH*3-1:0]   drv_pos,
  input logic [NCH*3-1:0]   drv_neg,
  input logic [NCH-1:0]     clamp,
  input logic [NCH-1:0]     ch_act
);

  logic [REP_W:0] gap;
  logic           seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (fire) begin
      gap  <= (REP_W+1)'(1);
      seen <= 1'b1;
    end else begin
      gap  <= gap + (REP_W+1)'(1);
    end
  end

  a_r1_fire_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> run);

  a_r1_fire_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen) |-> (gap == {1'b0, rep_period}));

  a_r9_run_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((drv_pos == '0) && (drv_neg == '0) && (&clamp)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r8_one_level: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_pos[c*3 +: 3], drv_neg[c*3 +: 3]}));

    a_r8_clamp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      clamp[c] |-> ({drv_pos[c*3 +: 3], drv_neg[c*3 +: 3]} == 6'd0));

    a_r2_start_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_act[c]) |-> $past(fire));
  end

endmodule

bind sonic_burst_gen sonic_burst_gen_chk #(.NCH(NCH), .REP_W(REP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .rep_period (rep_period),
  .fire       (fire),
  .drv_pos    (drv_pos),
  .drv_neg    (drv_neg),
  .clamp      (clamp),
  .ch_act     (ch_act)
);

// File: tb/test_sonic_burst_gen.sv
module test_sonic_burst_gen;

  localparam int NCH = 4, HP_W = 8, CNT_W = 5, REP_W = 16;
  localparam int REP = 150;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 run = 1'b0;
  logic [REP_W-1:0]     rep_period = REP_W'(REP);
  logic [NCH*HP_W-1:0]  cfg_half = '0;
  logic [NCH*CNT_W-1:0] cfg_pulses = '0;
  logic [NCH*2-1:0]     cfg_mode = '1;
  logic [NCH-1:0]       cfg_neg = '0;
  logic [NCH-1:0]       cfg_bridge = '0;
  logic                 fire;
  logic [NCH*3-1:0]     drv_pos, drv_neg;
  logic [NCH-1:0]       clamp;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sonic_burst_gen i_sonic_burst_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .rep_period(rep_period),
    .cfg_half(cfg_half), .cfg_pulses(cfg_pulses), .cfg_mode(cfg_mode),
    .cfg_neg(cfg_neg), .cfg_bridge(cfg_bridge),
    .fire(fire), .drv_pos(drv_pos), .drv_neg(drv_neg), .clamp(clamp)
  );

  // {mode[24:23], pulses[22:18], half[17:10], neg[9], bridge[8], expected active cycles[7:0]}
  localparam int NV = 9;
  localparam logic [24:0] VECS [NV] = '{
    {2'd0, 5'd5,  8'd4, 1'b0, 1'b0, 8'd40},
    {2'd0, 5'd5,  8'd2, 1'b1, 1'b1, 8'd20},
    {2'd0, 5'd3,  8'd0, 1'b0, 1'b1, 8'd6},
    {2'd1, 5'd0,  8'd3, 1'b0, 1'b0, 8'd150},
    {2'd2, 5'd5,  8'd2, 1'b0, 1'b0, 8'd26},
    {2'd2, 5'd4,  8'd5, 1'b1, 1'b1, 8'd55},
    {2'd0, 5'd0,  8'd3, 1'b0, 1'b0, 8'd0},
    {2'd3, 5'd5,  8'd2, 1'b0, 1'b0, 8'd0},
    {2'd0, 5'd31, 8'd2, 1'b0, 1'b1, 8'd124}
  };

  // Expected {pos[2:0], neg[2:0]} k cycles after the start edge.
  function automatic logic [5:0] exp_drv(int k, int mode, int n, int h, int neg, int br);
    int he, idx, b;
    bit on, p;
    logic [2:0] one;
    he  = (h == 0) ? 1 : h;
    idx = k / he;
    on  = 1'b0;
    b   = 0;
    case (mode)
      0: begin on = (idx < 2 * n); b = br; end
      1: begin on = 1'b1; b = 2; end
      2: begin on = (idx < 3 + 2 * n); b = (idx < 3) ? 0 : 1; end
      default: on = 1'b0;
    endcase
    if (!on) return 6'd0;
    p   = ((idx % 2) == 0) ^ (neg != 0);
    one = 3'b001 << b;
    return p ? {one, 3'b000} : {3'b000, one};
  endfunction

  function automatic logic [5:0] got_drv(int c);
    return {drv_pos[c*3 +: 3], drv_neg[c*3 +: 3]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_ch(int c, int mode, int n, int h, int neg, int br);
    cfg_mode[c*2 +: 2]        = 2'(mode);
    cfg_pulses[c*CNT_W +: CNT_W] = CNT_W'(n);
    cfg_half[c*HP_W +: HP_W]  = HP_W'(h);
    cfg_neg[c]                = neg[0];
    cfg_bridge[c]             = br[0];
  endtask

  task automatic stop_and_check(string tag);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    check((drv_pos == '0) && (drv_neg == '0) && (&clamp), "R9", tag,
          int'({drv_pos, drv_neg}), 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int mode, n, h, neg, br, expact;
    int bad0, bad1, bad3, badf, actcnt, k0a, k0e;
    logic [5:0] e;

    repeat (3) @(negedge clk);
    check((&clamp) && (drv_pos == '0) && (drv_neg == '0) && !fire, "R8",
          "state in reset", int'({drv_pos, drv_neg}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check((&clamp) && (drv_pos == '0) && (drv_neg == '0) && !fire, "R8",
          "idle after reset", int'({drv_pos, drv_neg, fire}), 0);

    // Table walk: ch0 = vector, ch1 = same with flipped polarity, ch2 = same, ch3 off.
    for (int v = 0; v < NV; v++) begin
      mode   = int'(VECS[v][24:23]);
      n      = int'(VECS[v][22:18]);
      h      = int'(VECS[v][17:10]);
      neg    = int'(VECS[v][9]);
      br     = int'(VECS[v][8]);
      expact = int'(VECS[v][7:0]);
      @(negedge clk);
      rep_period = REP_W'(REP);
      set_ch(0, mode, n, h, neg, br);
      set_ch(1, mode, n, h, 1 - neg, br);
      set_ch(2, mode, n, h, neg, br);
      set_ch(3, 3, n, h, neg, br);
      run = 1'b1;
      bad0 = 0; bad1 = 0; bad3 = 0; badf = 0; actcnt = 0; k0a = 0; k0e = 0;
      for (int k = 0; k < REP + 40; k++) begin
        int kk;
        @(negedge clk);
        kk = (mode == 1 || k < REP) ? k : k - REP;
        e = exp_drv(kk, mode, n, h, neg, br);
        if (got_drv(0) !== e) begin
          if (bad0 == 0) begin k0a = int'(got_drv(0)); k0e = int'(e); end
          bad0++;
        end
        if (got_drv(2) !== e) bad0++;
        if (got_drv(1) !== exp_drv(kk, mode, n, h, 1 - neg, br)) bad1++;
        if (got_drv(3) !== 6'd0 || clamp[3] !== 1'b1) bad3++;
        if (fire !== ((k == REP - 1) ? 1'b1 : 1'b0)) badf++;
        if (k < REP && !clamp[0]) actcnt++;
      end
      check(bad0 == 0, (mode == 1) ? "R6" : (mode == 2) ? "R7" : "R3/R4",
            $sformatf("vector %0d waveform ch0", v), k0a, k0e);
      check(bad1 == 0, "R5", $sformatf("vector %0d antiphase ch1 mismatches", v), bad1, 0);
      check(bad3 == 0, "R10", $sformatf("vector %0d off channel mismatches", v), bad3, 0);
      check(actcnt == expact, "R4", $sformatf("vector %0d active cycles", v), actcnt, expact);
      check(badf == 0, "R1", $sformatf("vector %0d fire timing mismatches", v), badf, 0);
      stop_and_check($sformatf("vector %0d quiet after run low", v));
    end

    // R2: settings changed during a burst apply only to the next burst.
    @(negedge clk);
    rep_period = REP_W'(60);
    set_ch(0, 0, 4, 3, 0, 0);
    run = 1'b1;
    bad0 = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (k == 5) set_ch(0, 0, 2, 1, 1, 1);
      e = (k < 60) ? exp_drv(k, 0, 4, 3, 0, 0) : exp_drv(k - 60, 0, 2, 1, 1, 1);
      if (got_drv(0) !== e) bad0++;
    end
    check(bad0 == 0, "R2", "settings captured at start only, mismatches", bad0, 0);
    stop_and_check("after R2 case");

    // R11: continuous channel ignores later strobes and a mid-burst half change.
    @(negedge clk);
    rep_period = REP_W'(10);
    set_ch(0, 1, 0, 3, 0, 0);
    run = 1'b1;
    bad0 = 0; badf = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 2) cfg_half[0 +: HP_W] = HP_W'(1);
      if (fire) badf++;
      if (got_drv(0) !== exp_drv(k, 1, 0, 3, 0, 0)) bad0++;
    end
    check(bad0 == 0, "R11", "continuous wave kept phase across strobes, mismatches", bad0, 0);
    check(badf == 4, "R1", "strobes seen with period 10 in 40 cycles", badf, 4);
    stop_and_check("continuous stopped by run low");

    // R2: no burst before the first strobe; a set-up channel stays clamped while run is low.
    set_ch(0, 0, 5, 2, 0, 0);
    repeat (5) @(negedge clk);
    check(clamp[0] === 1'b1 && got_drv(0) === 6'd0, "R2", "no start without strobe",
          int'(got_drv(0)), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule